// File: doc/BRIEF.md
# Low-Power Periodic Wake Timer

This block times the periods a system spends in a stop or sleep state and produces a periodic event at the end of each period. Software picks the period with a 3-bit interval code and a separate range bit. The code is written through a shared control register port, where a select bit says whether the write is meant for this timer. The range bit is written through a second configuration port. With the range bit clear, the period is the code times a base step. With it set, the step is eight times longer. A 1 ms strobe drives the timing, so with the default parameters the periods are 20 to 140 ms, or 160 to 1120 ms.

The timer arms on the cycle the system enters the low-power state. When a period ends, the kind of event depends on the high-side switch enables. If any switch is enabled, the timer raises a one-cycle sense pulse, reloads and keeps running. If none is enabled, it raises a one-cycle wake pulse and stops. Code 000 keeps the timer idle. Three things disarm the timer and clear its count: leaving the low-power state, writing the interval code and writing the range bit. Only the next entry into the low-power state arms it again.

Top module: `lp_wake_timer`

## Requirements
- R1: With interval code 000, no sense or wake pulse is ever produced, for either value of the range bit.
- R2: With the range bit at 0, a nonzero code C gives a period of C*STEP_TICKS tick strobes (C*20 ms at the defaults).
- R3: With the range bit at 1, a nonzero code C gives a period of C*STEP_TICKS*EXT_SCALE tick strobes (C*160 ms at the defaults).
- R4: The interval code register (reset 000) takes `ctl_code_i` only on a cycle with `ctl_wr_i`=1 and `ctl_sel_i`=1. A control write with `ctl_sel_i`=0 leaves the code unchanged.
- R5: The range bit (reset 0) is loaded from `ext_bit_i` only on a cycle with `ext_wr_i`=1.
- R6: The timer counts only after a 0-to-1 transition of `lowpwr_i`. Tick strobes give no event while `lowpwr_i` is 0 or before that entry.
- R7: When a period ends and any bit of `hs_en_i` is 1, `sense_o` pulses for one cycle and the next period of the same length starts at once. This repeats while `lowpwr_i` stays 1.
- R8: When a period ends and `hs_en_i` is all zero, `wake_o` pulses for one cycle. After that, no further event comes until `lowpwr_i` falls and rises again.
- R9: A low level on `lowpwr_i` clears the count and disarms the timer. The next entry starts a full period.
- R10: An interval-code write (`ctl_sel_i`=1) or a range-bit write disarms the timer until the next entry into the low-power state.
- R11: A pulse is registered. It is high in the clock cycle right after the edge that samples the period's final tick strobe, and `sense_o` and `wake_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle time base strobe (1 ms) |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_sel_i | input | 1 | Write target select: 1 = interval code, 0 = other prescaler |
| ctl_code_i | input | 3 | Interval code written when selected |
| ext_wr_i | input | 1 | Configuration register write strobe |
| ext_bit_i | input | 1 | Range bit: 1 multiplies the step by EXT_SCALE |
| lowpwr_i | input | 1 | High while the system is in stop or sleep |
| hs_en_i | input | N_HS | High-side switch enable flags |
| sense_o | output | 1 | One-cycle cyclic sense request |
| wake_o | output | 1 | One-cycle forced wake-up request |

## Verification
The bench sweeps all eight codes against both range-bit values and two switch-enable patterns, counting tick strobes from entry to the first event. This separates the two period scales and the code-000 idle case, and shows which event kind each pattern gives. A second period run after each event shows repetition for sense and silence after a wake. Directed sequences cover a deselected control write, leaving and re-entering the low-power state mid-period, and a rewrite while armed. Each of these would show up as a shifted or missing event count.

// File: rtl/lpw_pkg.sv
package lpw_pkg;
  localparam int CODE_W = 3;
  localparam int CODE_MAX = (1 << CODE_W) - 1;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_SENSE = 2'd1,
    EV_WAKE  = 2'd2
  } ev_kind_t;
endpackage

// File: rtl/lpw_interval_decode.sv
module lpw_interval_decode
  import lpw_pkg::*;
#(
  parameter int STEP_TICKS = 20,
  parameter int EXT_SCALE  = 8,
  parameter int CNT_W      = 10
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic              ext_i,
  output logic [CNT_W-1:0]  interval_o
);
  localparam int SCALE_LO = STEP_TICKS;
  localparam int SCALE_HI = STEP_TICKS * EXT_SCALE;

  always_comb begin
    if (ext_i) interval_o = CNT_W'(int'(code_i) * SCALE_HI);
    else       interval_o = CNT_W'(int'(code_i) * SCALE_LO);
  end
endmodule

// File: rtl/lpw_period_counter.sv
module lpw_period_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm_i,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic             hs_any_i,
  input  logic [CNT_W-1:0] interval_i,
  output logic             armed_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             last_tick;

  assign last_tick = armed_o && tick_i && (cnt_q == CNT_W'(1));
  assign expire_o  = last_tick && !clear_i && !arm_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_o <= 1'b0;
      cnt_q   <= '0;
    end else if (clear_i) begin
      armed_o <= 1'b0;
      cnt_q   <= '0;
    end else if (arm_i) begin
      armed_o <= (interval_i != '0);
      cnt_q   <= interval_i;
    end else if (armed_o && tick_i) begin
      if (cnt_q == CNT_W'(1)) begin
        if (hs_any_i) begin
          cnt_q <= interval_i;
        end else begin
          armed_o <= 1'b0;
          cnt_q   <= '0;
        end
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  // R2/R3: a live count stays between 1 and the decoded period
  a_r2_cnt_nonzero: assert property (@(posedge clk) disable iff (rst)
    armed_o |-> (cnt_q != '0));
  a_r3_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
    armed_o |-> (cnt_q <= interval_i));
  a_r9_clear_disarms: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> !armed_o);
endmodule

// File: rtl/lpw_event_out.sv
module lpw_event_out
  import lpw_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic expire_i,
  input  logic hs_any_i,
  output logic sense_o,
  output logic wake_o
);
  ev_kind_t kind;

  always_comb begin
    if (!expire_i)     kind = EV_NONE;
    else if (hs_any_i) kind = EV_SENSE;
    else               kind = EV_WAKE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sense_o <= 1'b0;
      wake_o  <= 1'b0;
    end else begin
      sense_o <= (kind == EV_SENSE);
      wake_o  <= (kind == EV_WAKE);
    end
  end

  a_r11_one_kind: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sense_o, wake_o}));
  a_r11_registered: assert property (@(posedge clk) disable iff (rst)
    !expire_i |=> !(sense_o || wake_o));
endmodule

// File: rtl/lp_wake_timer.sv
module lp_wake_timer
  import lpw_pkg::*;
#(
  parameter int STEP_TICKS = 20,
  parameter int EXT_SCALE  = 8,
  parameter int N_HS       = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              ctl_wr_i,
  input  logic              ctl_sel_i,
  input  logic [CODE_W-1:0] ctl_code_i,
  input  logic              ext_wr_i,
  input  logic              ext_bit_i,
  input  logic              lowpwr_i,
  input  logic [N_HS-1:0]   hs_en_i,
  output logic              sense_o,
  output logic              wake_o
);
  localparam int MAX_TICKS = CODE_MAX * STEP_TICKS * EXT_SCALE;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  logic [CODE_W-1:0] code_q;
  logic              ext_q;
  logic              lowpwr_q;
  logic              code_wr, entry, clear, hs_any, armed, expire;
  logic [CNT_W-1:0]  interval;

  assign code_wr = ctl_wr_i && ctl_sel_i;
  assign entry   = lowpwr_i && !lowpwr_q;
  assign clear   = !lowpwr_i || code_wr || ext_wr_i;
  assign hs_any  = |hs_en_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q   <= '0;
      ext_q    <= 1'b0;
      lowpwr_q <= 1'b0;
    end else begin
      lowpwr_q <= lowpwr_i;
      if (code_wr)  code_q <= ctl_code_i;
      if (ext_wr_i) ext_q  <= ext_bit_i;
    end
  end

  lpw_interval_decode #(
    .STEP_TICKS(STEP_TICKS), .EXT_SCALE(EXT_SCALE), .CNT_W(CNT_W)
  ) u_dec (
    .code_i(code_q), .ext_i(ext_q), .interval_o(interval)
  );

  lpw_period_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .arm_i(entry), .clear_i(clear), .tick_i(tick_i),
    .hs_any_i(hs_any), .interval_i(interval), .armed_o(armed),
    .expire_o(expire)
  );

  lpw_event_out u_ev (
    .clk(clk), .rst(rst), .expire_i(expire), .hs_any_i(hs_any),
    .sense_o(sense_o), .wake_o(wake_o)
  );

  a_r1_idle_on_zero: assert property (@(posedge clk) disable iff (rst)
    (code_q == '0) |-> !armed);
  a_r6_low_disarmed: assert property (@(posedge clk) disable iff (rst)
    !lowpwr_i |=> !armed);
  a_r7_sense_keeps_running: assert property (@(posedge clk) disable iff (rst)
    (sense_o && lowpwr_i && !code_wr && !ext_wr_i && !entry) |-> armed);
  a_r8_wake_stops: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> !armed);
  a_r10_write_disarms: assert property (@(posedge clk) disable iff (rst)
    (code_wr || ext_wr_i) |=> !armed);
endmodule

// File: tb/sim_lp_wake_timer.sv
`timescale 1ns/1ps
module sim_lp_wake_timer;
  localparam int STEP = 2;
  localparam int EXT  = 8;
  localparam int NHS  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, ctl_wr = 1'b0, ctl_sel = 1'b0, ext_wr = 1'b0, ext_bit = 1'b0;
  logic lowpwr = 1'b0;
  logic [2:0] ctl_code = '0;
  logic [NHS-1:0] hs = '0;
  logic sense, wake;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lp_wake_timer #(.STEP_TICKS(STEP), .EXT_SCALE(EXT), .N_HS(NHS)) u0 (
    .clk(clk), .rst(rst), .tick_i(tick), .ctl_wr_i(ctl_wr), .ctl_sel_i(ctl_sel),
    .ctl_code_i(ctl_code), .ext_wr_i(ext_wr), .ext_bit_i(ext_bit),
    .lowpwr_i(lowpwr), .hs_en_i(hs), .sense_o(sense), .wake_o(wake)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input bit sel, input logic [2:0] c);
    @(negedge clk); ctl_wr = 1; ctl_sel = sel; ctl_code = c;
    @(negedge clk); ctl_wr = 0; ctl_sel = 0;
  endtask

  task automatic wr_ext(input bit b);
    @(negedge clk); ext_wr = 1; ext_bit = b;
    @(negedge clk); ext_wr = 0;
  endtask

  task automatic enter();
    @(negedge clk); lowpwr = 1;
    @(negedge clk);
  endtask

  task automatic leave();
    @(negedge clk); lowpwr = 0;
    @(negedge clk);
  endtask

  // kind: 0 none, 1 sense, 2 wake, 3 both; idx = tick count at first event
  task automatic run_ticks(input int n, output int idx, output int kind);
    idx = 0; kind = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
      if (sense || wake) begin
        idx = i; kind = {30'd0, wake, sense};
        return;
      end
      @(negedge clk);
      if (sense || wake) begin
        idx = -i; kind = {30'd0, wake, sense};
        return;
      end
    end
  endtask

  function automatic int period(input int c, input bit e);
    return c * STEP * (e ? EXT : 1);
  endfunction

  initial begin
    repeat (1500000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int idx, kind, exp;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(!sense && !wake, "reset R11", {sense, wake}, 0);

    // Sweep: R1 R2 R3 R5 R7 R8 R11
    for (int e = 0; e < 2; e++) begin
      for (int c = 0; c < 8; c++) begin
        for (int h = 0; h < 2; h++) begin
          leave();
          wr_ctl(1, 3'(c));
          wr_ext(e[0]);
          hs = h ? NHS'(1 << (c % NHS)) : '0;
          enter();
          exp = period(c, e[0]);
          if (c == 0) begin
            run_ticks(130, idx, kind);
            check(kind == 0, "R1 code zero idle", kind, 0);
          end else begin
            run_ticks(exp + 3, idx, kind);
            check(idx == exp, e ? "R3 period" : "R2 period", idx, exp);
            check(kind == (h ? 1 : 2), h ? "R7 sense kind" : "R8 wake kind", kind, h ? 1 : 2);
            run_ticks(exp + 3, idx, kind);
            if (h) check(idx == exp && kind == 1, "R7 repeat", idx, exp);
            else   check(kind == 0, "R8 stop after wake", kind, 0);
          end
        end
      end
    end

    // R6: ticks with low-power low do nothing; then entry starts counting
    leave();
    wr_ctl(1, 3'd1); wr_ext(0); hs = 4'b0010;
    run_ticks(10, idx, kind);
    check(kind == 0, "R6 no count before entry", kind, 0);
    enter();
    run_ticks(10, idx, kind);
    check(idx == 2 && kind == 1, "R6 count after entry", idx, 2);

    // R4: deselected write leaves code 3 intact
    leave();
    wr_ctl(1, 3'd3);
    wr_ctl(0, 3'd7);
    enter();
    run_ticks(20, idx, kind);
    check(idx == 6, "R4 deselected write ignored", idx, 6);

    // R9: leave mid-period, re-enter gives a full period
    run_ticks(4, idx, kind);
    leave();
    run_ticks(10, idx, kind);
    check(kind == 0, "R9 silent after leave", kind, 0);
    enter();
    run_ticks(20, idx, kind);
    check(idx == 6, "R9 full period after re-entry", idx, 6);

    // R10: rewrite while armed disarms until next entry
    run_ticks(3, idx, kind);
    wr_ctl(1, 3'd3);
    run_ticks(20, idx, kind);
    check(kind == 0, "R10 code write disarms", kind, 0);
    leave(); enter();
    run_ticks(3, idx, kind);
    wr_ext(0);
    run_ticks(20, idx, kind);
    check(kind == 0, "R10 ext write disarms", kind, 0);
    leave(); enter();
    run_ticks(20, idx, kind);
    check(idx == 6, "R10 re-entry after write", idx, 6);

    // R11: pulse lasts exactly one cycle
    run_ticks(5, idx, kind);
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    check(sense && !wake, "R11 pulse present", {wake, sense}, 1);
    @(negedge clk);
    check(!sense && !wake, "R11 pulse one cycle", {wake, sense}, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule